// File: doc/BRIEF.md
# Variable-Page Joint Translation Buffer

This block is a fully associative address translation buffer that instruction fetch and data access share. Each entry holds one virtual tag for a pair of adjacent pages (an even page and an odd page), an 8-bit address-space number, a global flag, a 12-bit size mask, and two physical mappings. Each mapping is a frame number, a 2-bit caching attribute and a valid bit. The size mask is kept per entry, so any entry can map pages of 4 KB, 16 KB, 64 KB, 256 KB, 1 MB, 4 MB or 16 MB. The stored mask therefore decides, for its own entry, how many tag bits take part in the compare and which virtual address bit picks the even or odd half.

The lookup path is purely combinational, so the translation is ready in the same cycle as the cache index. It returns the physical address, the caching attribute, the index of the winning entry, and a three-way status: hit, invalid page, or miss. It also raises a flag when more than one entry matches. Refill software loads entries through an indexed write port. A write lands on the next rising clock edge.

Top module: `jtlb`

## Requirements
- R1: After reset no entry matches any address. Every lookup reports a miss, with `lk_paddr`, `lk_attr` and `lk_index` all zero.
- R2: A write with `wr_en` high and `wr_index` below the entry count replaces that entry on the next rising edge. A lookup made in the same cycle as the write still sees the old contents.
- R3: A write whose `wr_index` is at or above the entry count changes no entry.
- R4: An entry matches when all of the following hold: it has been written since reset; `lk_vaddr[31:13]` equals its tag in every bit except those whose size-mask bit is set (tag bit j is mask bit j for j < 12); and either its global flag is set or its address-space number equals `lk_asid`.
- R5: The size mask works in bit pairs (2j, 2j+1). A write that sets either bit of a pair stores both bits. With k set bits, the page is 2^(12+k) bytes and virtual bit 12+k selects the page: 0 selects the even page, 1 the odd page. The legal values are 0x000, 0x003, 0x00F, 0x03F, 0x0FF, 0x3FF and 0xFFF.
- R6: On a match, `lk_paddr` is built from the selected frame number with its low k bits replaced by `lk_vaddr[12+k-1:12]`, followed by `lk_vaddr[11:0]`.
- R7: Exactly one of `lk_hit`, `lk_invalid` and `lk_miss` is high. `lk_hit` means the selected page is valid. `lk_invalid` means an entry matched but its selected page is not valid. `lk_miss` means no entry matched.
- R8: On a match, `lk_attr` returns the 2-bit caching code stored for the selected page: 0 uncached, 1 write-through, 2 write-back, 3 reserved.
- R9: When two or more entries match, `lk_multi` is high and every result comes from the lowest-numbered matching entry.
- R10: `lk_index` gives the number of the winning entry. On a miss, `lk_index`, `lk_paddr` and `lk_attr` are zero.
- R11: When an entry's global flag is set, the entry matches whatever the value of `lk_asid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Address-space number of the lookup |
| lk_paddr | output | 32 | Translated physical address |
| lk_attr | output | 2 | Caching code of the selected page |
| lk_hit | output | 1 | Match on a valid page |
| lk_invalid | output | 1 | Match on a page whose valid bit is clear |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | Two or more entries matched |
| lk_index | output | 6 | Winning entry number |
| wr_en | input | 1 | Write strobe |
| wr_index | input | 6 | Entry to write |
| wr_vpn2 | input | 19 | Virtual tag (address bits 31:13) |
| wr_asid | input | 8 | Address-space number of the entry |
| wr_global | input | 1 | Global flag of the entry |
| wr_mask | input | 12 | Page size mask |
| wr_pfn_even | input | 20 | Frame number of the even page |
| wr_attr_even | input | 2 | Caching code of the even page |
| wr_valid_even | input | 1 | Valid bit of the even page |
| wr_pfn_odd | input | 20 | Frame number of the odd page |
| wr_attr_odd | input | 2 | Caching code of the odd page |
| wr_valid_odd | input | 1 | Valid bit of the odd page |

## Verification
The directed part runs the lookup against entries of the smallest size, the largest size and an intermediate 1 MB size. Addresses on either side of each entry's select bit show whether the select bit moves with the mask and whether the frame bits are merged at the right width. A second entry of a different size, placed over a global 16 MB entry, tells lowest-index priority apart from any other choice. Lookups with matching and non-matching address-space numbers tell the global flag apart from the compare itself. Other directed cases cover a same-cycle lookup during a write, a write to an out-of-range index, and a mask with only half of one pair set. A long random phase then mixes refills of random size, including out-of-range indices, with lookups drawn from a small tag pool so that overlaps and multi-matches occur. Every output is compared with a behavioural model on every cycle.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;

  localparam int MASK_W = 12;  // size mask bits, one per tag bit above 4 KB
  localparam int OFS_W  = 12;  // byte offset of the smallest page
  localparam int SEL_W  = 4;   // holds a span of 0..MASK_W

  typedef enum logic [1:0] {
    CA_UNCACHED = 2'd0,
    CA_WTHRU    = 2'd1,
    CA_WBACK    = 2'd2,
    CA_RSVD     = 2'd3
  } cattr_e;

  // Force both bits of every pair to the OR of the pair.
  function automatic logic [MASK_W-1:0] pair_mask(input logic [MASK_W-1:0] m);
    logic [MASK_W-1:0] r;
    for (int j = 0; j < MASK_W / 2; j++) begin
      r[2*j]   = m[2*j] | m[2*j+1];
      r[2*j+1] = m[2*j] | m[2*j+1];
    end
    return r;
  endfunction

  // Position of the lowest clear mask bit: the number of merged frame bits.
  function automatic logic [SEL_W-1:0] span_of(input logic [MASK_W-1:0] m);
    logic [SEL_W-1:0] r;
    r = SEL_W'(MASK_W);
    for (int i = MASK_W - 1; i >= 0; i--) begin
      if (!m[i]) r = SEL_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/jtlb_entry.sv
module jtlb_entry
  import jtlb_pkg::*;
#(
  parameter  int VA_W   = 32,
  parameter  int PFN_W  = 20,
  parameter  int ASID_W = 8,
  localparam int VPN2_W = VA_W - OFS_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [PFN_W-1:0]  wr_pfn_e,
  input  logic [1:0]        wr_attr_e,
  input  logic              wr_valid_e,
  input  logic [PFN_W-1:0]  wr_pfn_o,
  input  logic [1:0]        wr_attr_o,
  input  logic              wr_valid_o,
  input  logic [VPN2_W-1:0] lk_vpn2,
  input  logic [MASK_W:0]   lk_low,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_match,
  output logic              lk_pg_valid,
  output logic [1:0]        lk_pg_attr,
  output logic [PFN_W-1:0]  lk_frame
);

  localparam int KEEP_W = VPN2_W - MASK_W;

  // state
  logic              loaded_q;
  logic [VPN2_W-1:0] vpn2_q,   vpn2_d;
  logic [ASID_W-1:0] asid_q,   asid_d;
  logic              global_q, global_d;
  logic [MASK_W-1:0] mask_q,   mask_d;
  logic [PFN_W-1:0]  pfn_q   [2];
  logic [PFN_W-1:0]  pfn_d   [2];
  cattr_e            attr_q  [2];
  cattr_e            attr_d  [2];
  logic [1:0]        valid_q, valid_d;

  // next state
  always_comb begin
    vpn2_d    = wr_vpn2;
    asid_d    = wr_asid;
    global_d  = wr_global;
    mask_d    = pair_mask(wr_mask);
    pfn_d[0]  = wr_pfn_e;
    pfn_d[1]  = wr_pfn_o;
    attr_d[0] = cattr_e'(wr_attr_e);
    attr_d[1] = cattr_e'(wr_attr_o);
    valid_d   = {wr_valid_o, wr_valid_e};
  end

  // registers, enabled by the entry select
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      vpn2_q   <= '0;
      asid_q   <= '0;
      global_q <= 1'b0;
      mask_q   <= '0;
      valid_q  <= '0;
      for (int p = 0; p < 2; p++) begin
        pfn_q[p]  <= '0;
        attr_q[p] <= CA_UNCACHED;
      end
    end else if (wr_sel) begin
      loaded_q <= 1'b1;
      vpn2_q   <= vpn2_d;
      asid_q   <= asid_d;
      global_q <= global_d;
      mask_q   <= mask_d;
      valid_q  <= valid_d;
      for (int p = 0; p < 2; p++) begin
        pfn_q[p]  <= pfn_d[p];
        attr_q[p] <= attr_d[p];
      end
    end
  end

  // compare and page resolution
  logic [VPN2_W-1:0] cmp_keep;
  logic              tag_eq;
  logic              asid_ok;
  logic [SEL_W-1:0]  span;
  logic              pg;

  always_comb begin
    cmp_keep = {{KEEP_W{1'b1}}, ~mask_q};
    tag_eq   = ((lk_vpn2 ^ vpn2_q) & cmp_keep) == '0;
    asid_ok  = global_q || (asid_q == lk_asid);
    lk_match = loaded_q && tag_eq && asid_ok;
    span     = span_of(mask_q);
    pg       = lk_low[span];
    lk_pg_valid = valid_q[pg];
    lk_pg_attr  = attr_q[pg];
    lk_frame    = pfn_q[pg];
    for (int i = 0; i < MASK_W; i++) begin
      if (SEL_W'(i) < span) lk_frame[i] = lk_low[i];
    end
  end

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel |=> (loaded_q && vpn2_q == $past(wr_vpn2) && asid_q == $past(wr_asid)
                && pfn_q[0] == $past(wr_pfn_e) && pfn_q[1] == $past(wr_pfn_o))); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> ($stable(vpn2_q) && $stable(mask_q) && $stable(loaded_q)
                 && $stable(valid_q))); // R3

endmodule

// File: rtl/jtlb_pick.sv
module jtlb_pick #(
  parameter  int N     = 48,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic [N-1:0]     grant,
  output logic [IDX_W-1:0] idx,
  output logic             any,
  output logic             multi
);

  always_comb begin
    grant = req & (~req + N'(1));
    multi = |(req & (req - N'(1)));
    any   = |req;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | IDX_W'(i);
    end
  end

endmodule

// File: rtl/jtlb_mux.sv
module jtlb_mux #(
  parameter int N = 48,
  parameter int W = 23
) (
  input  logic [N-1:0] grant,
  input  logic [W-1:0] rsp [N],
  output logic [W-1:0] sel
);

  always_comb begin
    sel = '0;
    for (int i = 0; i < N; i++) begin
      sel = sel | (rsp[i] & {W{grant[i]}});
    end
  end

endmodule

// File: rtl/jtlb.sv
module jtlb
  import jtlb_pkg::*;
#(
  parameter  int N_ENTRIES = 48,
  parameter  int VA_W      = 32,
  parameter  int PFN_W     = 20,
  parameter  int ASID_W    = 8,
  localparam int IDX_W     = $clog2(N_ENTRIES),
  localparam int VPN2_W    = VA_W - OFS_W - 1,
  localparam int PA_W      = PFN_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  output logic [PA_W-1:0]   lk_paddr,
  output logic [1:0]        lk_attr,
  output logic              lk_hit,
  output logic              lk_invalid,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_index,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [VPN2_W-1:0] wr_vpn2,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [PFN_W-1:0]  wr_pfn_even,
  input  logic [1:0]        wr_attr_even,
  input  logic              wr_valid_even,
  input  logic [PFN_W-1:0]  wr_pfn_odd,
  input  logic [1:0]        wr_attr_odd,
  input  logic              wr_valid_odd
);

  localparam int RSP_W = PFN_W + 3;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address slices
  logic [VPN2_W-1:0] lk_vpn2;
  logic [MASK_W:0]   lk_low;
  assign lk_vpn2 = lk_vaddr[VA_W-1:OFS_W+1];
  assign lk_low  = lk_vaddr[OFS_W+MASK_W:OFS_W];

  logic [N_ENTRIES-1:0] wr_sel;
  logic [N_ENTRIES-1:0] match;
  logic [RSP_W-1:0]     rsp [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    logic             e_valid;
    logic [1:0]       e_attr;
    logic [PFN_W-1:0] e_frame;

    assign wr_sel[g] = wr_en && (wr_index == IDX_W'(g));

    jtlb_entry #(
      .VA_W   (VA_W),
      .PFN_W  (PFN_W),
      .ASID_W (ASID_W)
    ) u_ent (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .wr_sel      (wr_sel[g]),
      .wr_vpn2     (wr_vpn2),
      .wr_asid     (wr_asid),
      .wr_global   (wr_global),
      .wr_mask     (wr_mask),
      .wr_pfn_e    (wr_pfn_even),
      .wr_attr_e   (wr_attr_even),
      .wr_valid_e  (wr_valid_even),
      .wr_pfn_o    (wr_pfn_odd),
      .wr_attr_o   (wr_attr_odd),
      .wr_valid_o  (wr_valid_odd),
      .lk_vpn2     (lk_vpn2),
      .lk_low      (lk_low),
      .lk_asid     (lk_asid),
      .lk_match    (match[g]),
      .lk_pg_valid (e_valid),
      .lk_pg_attr  (e_attr),
      .lk_frame    (e_frame)
    );

    assign rsp[g] = {e_frame, e_attr, e_valid};
  end

  logic [N_ENTRIES-1:0] grant;
  logic [IDX_W-1:0]     win_idx;
  logic                 any_match;
  logic                 multi_match;

  jtlb_pick #(.N(N_ENTRIES)) u_pick (
    .req   (match),
    .grant (grant),
    .idx   (win_idx),
    .any   (any_match),
    .multi (multi_match)
  );

  logic [RSP_W-1:0] win_rsp;

  jtlb_mux #(.N(N_ENTRIES), .W(RSP_W)) u_mux (
    .grant (grant),
    .rsp   (rsp),
    .sel   (win_rsp)
  );

  // output formation
  always_comb begin
    lk_hit     = any_match && win_rsp[0];
    lk_invalid = any_match && !win_rsp[0];
    lk_miss    = !any_match;
    lk_multi   = multi_match;
    lk_attr    = win_rsp[2:1];
    lk_index   = win_idx;
    lk_paddr   = any_match ? {win_rsp[RSP_W-1:3], lk_vaddr[OFS_W-1:0]} : '0;
  end

  AST_GRANT_SINGLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant)); // R9

  AST_GRANT_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
    (grant & ~match) == '0); // R9

  AST_MULTI_HAS_TWO: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_multi |-> ($countones(match) >= 2)); // R9

  AST_ONE_STATUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot({lk_hit, lk_invalid, lk_miss})); // R7

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    lk_miss |-> (lk_paddr == '0 && lk_attr == '0 && lk_index == '0)); // R10

  AST_FAR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_en && wr_index >= IDX_W'(N_ENTRIES)) |-> (wr_sel == '0)); // R3

endmodule

// File: tb/jtlb_tb.sv
`timescale 1ns/1ps
module jtlb_tb;

  localparam int N = 48;

  logic        clk;
  logic        rst_n;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic [31:0] lk_paddr;
  logic [1:0]  lk_attr;
  logic        lk_hit, lk_invalid, lk_miss, lk_multi;
  logic [5:0]  lk_index;
  logic        wr_en;
  logic [5:0]  wr_index;
  logic [18:0] wr_vpn2;
  logic [7:0]  wr_asid;
  logic        wr_global;
  logic [11:0] wr_mask;
  logic [19:0] wr_pfn_even, wr_pfn_odd;
  logic [1:0]  wr_attr_even, wr_attr_odd;
  logic        wr_valid_even, wr_valid_odd;

  jtlb u_dut (
    .clk (clk), .rst_n (rst_n),
    .lk_vaddr (lk_vaddr), .lk_asid (lk_asid), .lk_paddr (lk_paddr),
    .lk_attr (lk_attr), .lk_hit (lk_hit), .lk_invalid (lk_invalid),
    .lk_miss (lk_miss), .lk_multi (lk_multi), .lk_index (lk_index),
    .wr_en (wr_en), .wr_index (wr_index), .wr_vpn2 (wr_vpn2),
    .wr_asid (wr_asid), .wr_global (wr_global), .wr_mask (wr_mask),
    .wr_pfn_even (wr_pfn_even), .wr_attr_even (wr_attr_even),
    .wr_valid_even (wr_valid_even), .wr_pfn_odd (wr_pfn_odd),
    .wr_attr_odd (wr_attr_odd), .wr_valid_odd (wr_valid_odd)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit          m_ld   [N];
  bit [18:0]   m_vpn  [N];
  int          m_asid [N];
  bit          m_g    [N];
  int          m_k    [N];
  bit [19:0]   m_pfn  [N][2];
  int          m_attr [N][2];
  bit          m_v    [N][2];

  // pending write
  bit        p_we;
  int        p_idx;
  bit [18:0] p_vpn;
  int        p_asid;
  bit        p_g;
  bit [11:0] p_mask;
  bit [19:0] p_pfn [2];
  int        p_attr [2];
  bit        p_v [2];

  // expected lookup
  bit        e_hit, e_inv, e_miss, e_multi;
  bit [31:0] e_pa;
  int        e_attr, e_idx;

  function automatic int pairs_to_k(input bit [11:0] m);
    int k = 0;
    for (int j = 0; j < 6; j++) if (m[2*j] || m[2*j+1]) k += 2;
    return k;
  endfunction

  task automatic model_look(input bit [31:0] va, input int asid);
    int first = -1;
    int cnt = 0;
    for (int i = 0; i < N; i++) begin
      if (m_ld[i] && ((va >> (13 + m_k[i])) == (32'(m_vpn[i]) >> m_k[i]))
          && (m_g[i] || m_asid[i] == asid)) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    e_multi = cnt > 1;
    if (first < 0) begin
      e_hit = 0; e_inv = 0; e_miss = 1; e_pa = 0; e_attr = 0; e_idx = 0;
    end else begin
      int k = m_k[first];
      int pg = int'((va >> (12 + k)) & 32'd1);
      bit [31:0] lowm = (32'd1 << (12 + k)) - 32'd1;
      e_miss = 0;
      e_hit  = m_v[first][pg];
      e_inv  = !m_v[first][pg];
      e_attr = m_attr[first][pg];
      e_idx  = first;
      e_pa   = (((32'(m_pfn[first][pg]) >> k) << (12 + k)) | (va & lowm));
    end
  endtask

  task automatic check(input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic set_write(input int idx, input bit [18:0] vpn, input int asid,
                           input bit g, input bit [11:0] mask,
                           input bit [19:0] pe, input int ae, input bit ve,
                           input bit [19:0] po, input int ao, input bit vo);
    p_we = 1; p_idx = idx; p_vpn = vpn; p_asid = asid; p_g = g; p_mask = mask;
    p_pfn[0] = pe; p_attr[0] = ae; p_v[0] = ve;
    p_pfn[1] = po; p_attr[1] = ao; p_v[1] = vo;
  endtask

  // One cycle: drive at the falling edge, compare 1 ns later, commit the
  // write to the model after the rising edge.
  task automatic step(input bit [31:0] va, input int asid, input string tag,
                      input bit lit_en, input bit [31:0] lit_pa);
    @(negedge clk);
    lk_vaddr      = va;
    lk_asid       = 8'(asid);
    wr_en         = p_we;
    wr_index      = 6'(p_idx);
    wr_vpn2       = p_vpn;
    wr_asid       = 8'(p_asid);
    wr_global     = p_g;
    wr_mask       = p_mask;
    wr_pfn_even   = p_pfn[0];
    wr_attr_even  = 2'(p_attr[0]);
    wr_valid_even = p_v[0];
    wr_pfn_odd    = p_pfn[1];
    wr_attr_odd   = 2'(p_attr[1]);
    wr_valid_odd  = p_v[1];
    #1;
    model_look(va, asid);
    check(tag, "hit",     lk_hit,     e_hit);
    check(tag, "invalid", lk_invalid, e_inv);
    check(tag, "miss",    lk_miss,    e_miss);
    check(tag, "multi",   lk_multi,   e_multi);
    check(tag, "paddr",   lk_paddr,   e_pa);
    check(tag, "attr",    lk_attr,    e_attr);
    check(tag, "index",   lk_index,   e_idx);
    if (lit_en) check(tag, "paddr literal", lk_paddr, lit_pa);
    @(posedge clk);
    if (p_we && p_idx < N) begin
      m_ld[p_idx]   = 1;
      m_vpn[p_idx]  = p_vpn;
      m_asid[p_idx] = p_asid;
      m_g[p_idx]    = p_g;
      m_k[p_idx]    = pairs_to_k(p_mask);
      for (int p = 0; p < 2; p++) begin
        m_pfn[p_idx][p]  = p_pfn[p];
        m_attr[p_idx][p] = p_attr[p];
        m_v[p_idx][p]    = p_v[p];
      end
    end
    p_we = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_ld[i] = 0;
    p_we = 0; p_idx = 0; p_vpn = 0; p_asid = 0; p_g = 0; p_mask = 0;
    for (int p = 0; p < 2; p++) begin p_pfn[p] = 0; p_attr[p] = 0; p_v[p] = 0; end
    rst_n = 0;
    lk_vaddr = 0; lk_asid = 0; wr_en = 0; wr_index = 0; wr_vpn2 = 0;
    wr_asid = 0; wr_global = 0; wr_mask = 0; wr_pfn_even = 0; wr_pfn_odd = 0;
    wr_attr_even = 0; wr_attr_odd = 0; wr_valid_even = 0; wr_valid_odd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(posedge clk);

    // R1: empty after reset
    step(32'h0002_1ABC, 0, "R1", 0, 0);
    step(32'h0000_0000, 0, "R1", 0, 0);

    // R2: 4 KB entry 0; same-cycle lookup sees the old (empty) contents
    set_write(0, 19'h00010, 0, 0, 12'h000, 20'h12345, 2, 1, 20'h54321, 1, 1);
    step(32'h0002_1ABC, 0, "R2", 0, 0);
    check("R2", "same-cycle miss", lk_miss, 1);
    step(32'h0002_1ABC, 0, "R6", 1, 32'h5432_1ABC);
    step(32'h0002_0ABC, 0, "R6", 1, 32'h1234_5ABC);
    check("R8", "attr write-back even", lk_attr, 2);
    step(32'h0002_1000, 0, "R8", 0, 0);
    check("R8", "attr write-through odd", lk_attr, 1);

    // R11: global 16 MB entry 5
    set_write(5, 19'h20000, 7, 1, 12'hFFF, 20'hABC00, 2, 1, 20'h77000, 0, 1);
    step(32'h0, 0, "R2", 0, 0);
    step(32'h4123_4567, 9, "R11", 1, 32'h7723_4567);
    check("R5", "16M odd select", lk_hit, 1);

    // R9: overlapping 4 KB entry 9, lowest index wins
    set_write(9, 19'h20000, 2, 0, 12'h000, 20'h00001, 1, 1, 20'h00002, 1, 1);
    step(32'h0, 0, "R2", 0, 0);
    step(32'h4000_0123, 2, "R9", 1, 32'hAB00_0123);
    check("R9", "multi flag", lk_multi, 1);
    check("R10", "winning index", lk_index, 5);

    // R7: 1 MB entry 47 with invalid even page
    set_write(47, 19'h40000, 1, 0, 12'h0FF, 20'h33300, 0, 0, 20'h44400, 3, 1);
    step(32'h0, 0, "R2", 0, 0);
    step(32'h8000_5000, 1, "R7", 0, 0);
    check("R7", "invalid even page", lk_invalid, 1);
    step(32'h8010_0000, 1, "R7", 1, 32'h4440_0000);
    check("R10", "last index", lk_index, 47);
    step(32'h8010_0000, 3, "R4", 0, 0);
    check("R4", "asid mismatch miss", lk_miss, 1);

    // R3: out-of-range index
    set_write(50, 19'h60000, 0, 1, 12'h000, 20'h1, 2, 1, 20'h2, 2, 1);
    step(32'h0, 0, "R3", 0, 0);
    step(32'hC000_0000, 0, "R3", 0, 0);
    check("R3", "far write ignored", lk_miss, 1);

    // R5: half-set mask pair behaves as 16 KB
    set_write(12, 19'h30000, 0, 1, 12'h001, 20'h11111, 1, 1, 20'h22222, 2, 1);
    step(32'h0, 0, "R2", 0, 0);
    step(32'h6000_5678, 0, "R5", 1, 32'h2222_1678);

    // random mix
    for (int it = 0; it < 4000; it++) begin
      bit [31:0] va;
      if ($urandom_range(0, 9) < 3) begin
        int kk = 2 * $urandom_range(0, 6);
        bit [11:0] mk = 12'((32'd1 << kk) - 1);
        bit [18:0] vp = 19'(($urandom_range(0, 7) << 10) | $urandom_range(0, 1023));
        set_write($urandom_range(0, 51), vp, $urandom_range(0, 3),
                  $urandom_range(0, 3) == 0, mk,
                  20'($urandom), $urandom_range(0, 3), $urandom_range(0, 1),
                  20'($urandom), $urandom_range(0, 3), $urandom_range(0, 1));
      end
      va = (32'(($urandom_range(0, 7) << 10) | $urandom_range(0, 1023)) << 13)
           | 32'($urandom_range(0, 8191));
      step(va, $urandom_range(0, 3), "R4", 0, 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule